// File: doc/BRIEF.md
# Line-Splitting DMA Request Issuer

This block turns one DMA command into a series of memory requests, none of which crosses a cache-line boundary. A command gives a direction (read or write), a start address, a byte length and a completion delay. The issuer walks the range line by line. The first piece runs to the end of the start line, the pieces in between are whole lines, and the last piece is whatever is left. Each piece goes out on a valid/ready request channel. For writes, each request carries the offset into the caller's write buffer where its data begins.

A refused request is parked. Nothing is offered again until the downstream raises a retry pulse, and then the same piece is offered, so the order never changes. Every accepted request is followed by one idle cycle on the channel. Each issued request's own size is remembered until its response arrives, and the bytes are tallied from those sizes rather than from the response's reported size, which may be rounded up to a full line. When the tally reaches the command length, a one-cycle completion pulse follows after the command's delay. An idle (drained) output is high whenever no request is awaiting its response. A sticky error flags a tally that overshoots the command length.

Top module: `dma_line_issuer`

## Requirements
- R1: Every request satisfies (address mod LINE_BYTES) + size <= LINE_BYTES. The requests of a command have contiguous addresses starting at the command address. Each size is min(bytes left, bytes to the end of the current line), and the sizes sum to the command length.
- R2: Each request carries the command's direction on `req_write` (1 = write). `req_off` equals the number of bytes already issued for the command, so the first request has offset 0.
- R3: When a request is offered and `req_ready` is low, `req_valid` is low from the next cycle on. It stays low until the cycle after a `req_retry` pulse, and then the same address and size are offered again.
- R4: In the cycle after a request is accepted (`req_valid` and `req_ready` both high), `req_valid` is low.
- R5: `drained` is high exactly when every accepted request has had its response. At most OUT_MAX requests are awaiting responses at any time.
- R6: Responses are taken in issue order, and each one adds its own request's size to the byte tally. `rsp_bytes` is ignored while any request is awaiting its response, and the command still completes on time with `err` low.
- R7: If the last response is presented in cycle c, `done` is high for exactly one cycle, cycle c + D + 1, where D is the command's `cmd_delay`.
- R8: A response that arrives with nothing awaiting its response adds `rsp_bytes` to the tally. If the tally then exceeds the command length, `err` rises and stays high until the next command is accepted.
- R9: `cmd_ready` is low from the cycle after a command is accepted until the cycle in which `done` pulses. A command offered during that time is not taken and does not disturb the requests already in progress.
- R10: After reset, `cmd_ready` and `drained` are high, and `req_valid`, `done` and `err` are low.
- R11: A zero-length command issues no request. It pulses `done` D + 1 cycles after the cycle in which it was offered and accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Issuer idle, command will be taken |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_delay | input | DLY_W | Cycles added before the completion pulse |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Downstream takes the request |
| req_retry | input | 1 | Downstream asks for a refused request again |
| req_write | output | 1 | Request direction |
| req_addr | output | ADDR_W | Request byte address |
| req_size | output | log2(LINE_BYTES)+1 | Request size in bytes |
| req_off | output | LEN_W | Offset of the request's data in the write buffer |
| rsp_valid | input | 1 | A response arrives (in issue order) |
| rsp_bytes | input | log2(LINE_BYTES)+1 | Size reported by the response |
| done | output | 1 | One-cycle completion pulse |
| drained | output | 1 | No request awaiting its response |
| err | output | 1 | Byte tally exceeded the command length |

## Verification
A wrong remaining-byte count or next-address register shows up on the very next offered request, as a size or address that departs from the line arithmetic. A corrupted size queue or outstanding counter moves the cycle of `done`, holds `drained` in the wrong state, or raises `err` on a clean command, all visible within one response of the fault. A lost refusal flag shows as `req_valid` returning before the retry pulse, and a missing pacing gap shows one cycle after an accepted request. The completion timer is judged to the exact cycle against the last response.

// File: rtl/dma_line_issuer.sv
module dma_line_issuer #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int OUT_MAX    = 4,
  parameter int DLY_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic                          cmd_write,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [LEN_W-1:0]              cmd_len,
  input  logic [DLY_W-1:0]              cmd_delay,
  output logic                          req_valid,
  input  logic                          req_ready,
  input  logic                          req_retry,
  output logic                          req_write,
  output logic [ADDR_W-1:0]             req_addr,
  output logic [$clog2(LINE_BYTES):0]   req_size,
  output logic [LEN_W-1:0]              req_off,
  input  logic                          rsp_valid,
  input  logic [$clog2(LINE_BYTES):0]   rsp_bytes,
  output logic                          done,
  output logic                          drained,
  output logic                          err
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SZ_W  = OFF_W + 1;
  localparam int PTR_W = $clog2(OUT_MAX);
  localparam int CNT_W = $clog2(OUT_MAX + 1);

  logic              busy, fin, gap, hold, wr_q, tmr_on, done_q, err_q;
  logic [ADDR_W-1:0] nxt;
  logic [LEN_W-1:0]  rem, off, total;
  logic [LEN_W:0]    acc;
  logic [DLY_W-1:0]  dly_q, tmr;
  logic [CNT_W-1:0]  outst;
  logic [PTR_W-1:0]  wp, rp;
  logic [SZ_W-1:0]   szq [OUT_MAX];

  logic [LEN_W-1:0]  room, chunk;
  logic              cmd_fire, issue, refuse, known, last_rsp, zero_cmd, finish;
  logic [SZ_W-1:0]   add;
  logic [LEN_W:0]    acc_nxt;
  logic [DLY_W-1:0]  fin_dly;

  assign room     = LEN_W'(LINE_BYTES) - LEN_W'(nxt[OFF_W-1:0]);
  assign chunk    = (rem < room) ? rem : room;
  assign cmd_ready = !busy;
  assign cmd_fire = cmd_valid && !busy;
  assign req_valid = busy && (rem != '0) && !gap && !hold && (outst != CNT_W'(OUT_MAX));
  assign issue    = req_valid && req_ready;
  assign refuse   = req_valid && !req_ready;
  assign known    = rsp_valid && (outst != '0);
  assign add      = known ? szq[rp] : rsp_bytes;
  assign acc_nxt  = acc + (LEN_W+1)'(add);
  assign last_rsp = known && busy && !fin && (acc_nxt == {1'b0, total});
  assign zero_cmd = cmd_fire && (cmd_len == '0);
  assign finish   = last_rsp || zero_cmd;
  assign fin_dly  = zero_cmd ? cmd_delay : dly_q;

  assign req_write = wr_q;
  assign req_addr  = nxt;
  assign req_size  = chunk[SZ_W-1:0];
  assign req_off   = off;
  assign done      = done_q;
  assign err       = err_q;
  assign drained   = (outst == '0);

  always_ff @(posedge clk) begin
    if (issue) szq[wp] <= chunk[SZ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; fin <= 1'b0; gap <= 1'b0; hold <= 1'b0; wr_q <= 1'b0;
      tmr_on <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      nxt <= '0; rem <= '0; off <= '0; total <= '0; acc <= '0;
      dly_q <= '0; tmr <= '0; outst <= '0; wp <= '0; rp <= '0;
    end else begin
      done_q <= 1'b0;
      outst  <= outst + CNT_W'(issue) - CNT_W'(known);
      if (issue) wp <= wp + 1'b1;
      if (known) rp <= rp + 1'b1;

      if (cmd_fire) begin
        busy <= 1'b1; fin <= 1'b0; wr_q <= cmd_write;
        nxt <= cmd_addr; rem <= cmd_len; off <= '0; total <= cmd_len;
        acc <= '0; dly_q <= cmd_delay; err_q <= 1'b0;
      end else if (rsp_valid) begin
        acc <= acc_nxt;
        if (acc_nxt > {1'b0, total}) err_q <= 1'b1;
      end

      if (issue) begin
        nxt <= nxt + ADDR_W'(chunk);
        rem <= rem - chunk;
        off <= off + chunk;
      end
      gap <= issue;

      if (refuse) hold <= 1'b1;
      else if (req_retry) hold <= 1'b0;

      if (finish) begin
        fin <= 1'b1;
        if (fin_dly == '0) begin
          done_q <= 1'b1; busy <= 1'b0;
        end else begin
          tmr <= fin_dly; tmr_on <= 1'b1;
        end
      end else if (tmr_on) begin
        tmr <= tmr - 1'b1;
        if (tmr == DLY_W'(1)) begin
          tmr_on <= 1'b0; done_q <= 1'b1; busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_line_issuer_chk.sv
module dma_line_issuer_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic                        cmd_ready,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [$clog2(LINE_BYTES):0] req_size,
  input logic                        done,
  input logic                        drained
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  AST_NO_LINE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0) && ((int'(req_addr[OFF_W-1:0]) + int'(req_size)) <= LINE_BYTES)); // R1
  AST_PARK_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !req_valid); // R3
  AST_SAME_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_addr) && $stable(req_size)); // R3
  AST_GAP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R4
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> drained); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready || done); // R9
endmodule

bind dma_line_issuer dma_line_issuer_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_size(req_size), .done(done), .drained(drained)
);

// File: tb/dma_line_issuer_bench.sv
module dma_line_issuer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, LEN_W = 16, LINE = 8, OUT_MAX = 4, DLY_W = 4;
  localparam int SZ_W = $clog2(LINE) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [DLY_W-1:0] cmd_delay = '0;
  logic req_valid, req_ready = 1'b0, req_retry = 1'b0, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [SZ_W-1:0] req_size, rsp_bytes = '0;
  logic [LEN_W-1:0] req_off;
  logic rsp_valid = 1'b0, done, drained, err;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_line_issuer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE),
                    .OUT_MAX(OUT_MAX), .DLY_W(DLY_W)) u_dma_line_issuer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_delay(cmd_delay),
    .req_valid(req_valid), .req_ready(req_ready), .req_retry(req_retry),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_bytes(rsp_bytes), .done(done), .drained(drained), .err(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R7 watchdog act=0 exp=1 (run hung)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run_cmd(input logic wr, input int addr, input int len, input int dly,
                         input int mode, input bit hold_cmd);
    int ea = addr, er = len, eo = 0, outm = 0, pres = 0, wait_rt = 0;
    int last_c = -1, cyc = 0, lat, room, sz;
    int dueq[$];
    bit prev_acc = 0, seen = 0;
    lat = (mode == 2) ? 9 : 2;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = ADDR_W'(addr);
    cmd_len = LEN_W'(len); cmd_delay = DLY_W'(dly);
    @(negedge clk);
    if (hold_cmd) begin
      cmd_addr = 16'h7777; cmd_len = 16'd3; cmd_write = ~wr;
    end else cmd_valid = 1'b0;
    chk(err == 1'b0, "R8 err cleared on accept", int'(err), 0);
    while (!seen && cyc < 600) begin
      req_ready = 1'b0; req_retry = 1'b0; rsp_valid = 1'b0;
      chk(drained == (outm == 0), "R5 drained", int'(drained), int'(outm == 0));
      if (done) begin
        seen = 1;
        cmd_valid = 1'b0;
        chk(cyc == last_c + dly + 1, (len == 0) ? "R11 done cycle" : "R7 done cycle", cyc, last_c + dly + 1);
        chk(er == 0, "R1 all bytes issued", er, 0);
        chk(err == 1'b0, "R6 no error with rounded responses", int'(err), 0);
      end else begin
        chk(cmd_ready == 1'b0, "R9 busy", int'(cmd_ready), 0);
        if (prev_acc) chk(!req_valid, "R4 gap after accept", int'(req_valid), 0);
        prev_acc = 0;
        if (wait_rt > 0) begin
          chk(!req_valid, "R3 parked until retry", int'(req_valid), 0);
          wait_rt--;
          if (wait_rt == 0) req_retry = 1'b1;
        end else if (req_valid && !prev_acc) begin
          room = LINE - (ea % LINE);
          sz = (er < room) ? er : room;
          chk(outm < OUT_MAX, "R5 outstanding limit", outm, OUT_MAX - 1);
          chk(int'(req_addr) == ea, "R1 address", int'(req_addr), ea);
          chk(int'(req_size) == sz, "R1 size", int'(req_size), sz);
          chk(int'(req_off) == eo, "R2 offset", int'(req_off), eo);
          chk(req_write == wr, "R2 direction", int'(req_write), int'(wr));
          pres++;
          if (mode == 1 && (pres % 2) == 1) begin
            wait_rt = 2;
          end else begin
            req_ready = 1'b1; prev_acc = 1;
            ea += sz; er -= sz; eo += sz; outm++;
            dueq.push_back(cyc + lat);
          end
        end
        if (dueq.size() > 0 && dueq[0] <= cyc) begin
          rsp_valid = 1'b1; rsp_bytes = SZ_W'(LINE);
          void'(dueq.pop_front());
          outm--;
          if (outm == 0 && er == 0) last_c = cyc;
        end
      end
      @(negedge clk);
      cyc++;
    end
    req_ready = 1'b0; req_retry = 1'b0; rsp_valid = 1'b0;
    chk(seen, "R7 done seen", int'(seen), 1);
    chk(!done, "R7 single-cycle pulse", int'(done), 0);
    chk(cmd_ready, "R9 idle after done", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R10 cmd_ready", int'(cmd_ready), 1);
    chk(!req_valid, "R10 req_valid", int'(req_valid), 0);
    chk(drained, "R10 drained", int'(drained), 1);
    chk(!done, "R10 done", int'(done), 0);
    chk(!err, "R10 err", int'(err), 0);

    for (int o = 0; o < LINE; o++)
      for (int l = 0; l <= 20; l++)
        run_cmd(l[0], 16'h100 + o, l, l % 4, (o + l) % 3, o == 3);

    run_cmd(1'b1, 16'h205, 100, 15, 2, 1'b0);
    run_cmd(1'b0, 16'h3f9, 37, 0, 1, 1'b0);

    @(negedge clk);
    rsp_valid = 1'b1; rsp_bytes = SZ_W'(1);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(err == 1'b1, "R8 stray response overshoot", int'(err), 1);
    chk(drained == 1'b1, "R8 stray keeps drained", int'(drained), 1);
    @(negedge clk);
    chk(err == 1'b1, "R8 err sticky", int'(err), 1);
    run_cmd(1'b0, 16'h40, 9, 1, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule